// File: doc/BRIEF.md
# Linked-Ring Transmit DMA Engine

This block walks a ring of transmit descriptors in memory and turns the packet bytes they point at into a byte stream. A descriptor is four 32-bit words on a 16-byte boundary: a control word at offset 0, the address of the following descriptor at offset 4, the byte address of the payload at offset 8 and a status word at offset 12. The engine reads the first three words, streams the payload one byte per handshake, and then writes a done flag into the status word. After that it follows the next pointer. Software closes the ring by pointing the last descriptor back at the first.

Software controls the flow with a park flag in each control word. The engine refuses to transfer a descriptor whose park flag is set and waits on it instead. It re-reads the control word after a programmable idle gap. Software can also force an immediate re-read with a resume command. A stop command ends the channel cleanly. The command port takes three actions: start at a descriptor address, stop, and resume.

Top module: `txring_dma`

## Requirements
- R1: After reset the engine is idle: `mem_req`, `st_valid` and `parked` are low, and no memory access is made until a start command arrives.
- R2: A start command (`cmd_op` = 2'b01) is honoured only while idle. It fetches the control word at `cmd_addr` with its low four bits cleared, then the next pointer at +4 and the payload pointer at +8.
- R3: Control word layout:
  - bit 31 is park, bit 30 is end-of-packet and bit 29 is start-of-packet;
  - the low `LEN_W` bits are the byte count;
  - bits 28 and 27 have no effect on the transfer.
- R4: Payload bytes leave in ascending address order from any byte alignment. The byte at an address with low bits k is taken from bits 8k+7:8k of its word. Each group of four bytes costs one word read.
- R5: `st_first` is high on the first byte of a descriptor only when its start bit is set. `st_last` is high on its final byte only when its end bit is set.
- R6: After a descriptor's last byte, or at once when the count is zero, the engine writes 32'h8000_0000 to offset 12. It then fetches the descriptor named by the next pointer, including the wrap back to the first descriptor.
- R7: A descriptor with park set causes no byte and no write, and it raises `parked`. With a zero-wait memory its control word is read again every `poll_interval` + 2 cycles.
- R8: A descriptor whose park bit software clears is transferred on the next poll. A resume command (`cmd_op` = 2'b11) while parked makes the engine request its control word in the following cycle.
- R9: A stop command (`cmd_op` = 2'b10) lets a memory access already requested finish and then returns to idle. It drops a pending stream byte and writes no done flag for the interrupted descriptor.
- R10: A memory request keeps its address, direction and write data until `mem_ready`. A stream byte keeps its data and flags until `st_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 01 start, 10 stop, 11 resume |
| cmd_addr | input | ADDR_W | First descriptor address for start |
| poll_interval | input | POLL_W | Idle gap between re-reads of a parked descriptor |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Access accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| st_valid | output | 1 | Stream byte valid |
| st_data | output | 8 | Stream byte |
| st_first | output | 1 | First byte of a packet |
| st_last | output | 1 | Final byte of a packet |
| st_ready | input | 1 | Stream sink accepts the byte |
| parked | output | 1 | Engine is waiting on a parked descriptor |

## Verification
The bench builds the engine with ADDR_W = 10, LEN_W = 8 and POLL_W = 4. A 1 KB word memory then covers every address the engine can form. With only four interval bits, every poll interval from 0 to 15 is swept and each re-read gap is measured against `poll_interval` + 2.

A five-descriptor ring is run under every pairing of three memory-stall and three stream-backpressure patterns. The ring mixes unaligned payloads, single-flag packets, a zero-length entry and stray bits 28/27. Expected bytes and flags come from an arithmetic fill pattern.

Further runs cover four cases:
- release of a parked descriptor through polling;
- the one-cycle reaction to resume;
- a stop in the middle of a payload;
- a restart at an unaligned start address.

// File: rtl/txring_pkg.sv
package txring_pkg;

   typedef enum logic [1:0] {
      CMD_NONE   = 2'b00,
      CMD_START  = 2'b01,
      CMD_STOP   = 2'b10,
      CMD_RESUME = 2'b11
   } txr_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CTL,
      ST_NXT,
      ST_PTR,
      ST_WORD,
      ST_SEND,
      ST_DONE,
      ST_PARK
   } txr_state_e;

   // control word bit positions (the layout software writes)
   localparam int unsigned PARK_BIT = 31;
   localparam int unsigned EOP_BIT  = 30;
   localparam int unsigned SOP_BIT  = 29;
   // status word flag written on completion
   localparam int unsigned DONE_BIT = 31;

   // word offsets inside a 16-byte descriptor
   localparam logic [3:0] OFS_CTL  = 4'h0;
   localparam logic [3:0] OFS_NXT  = 4'h4;
   localparam logic [3:0] OFS_PTR  = 4'h8;
   localparam logic [3:0] OFS_STAT = 4'hC;

endpackage

// File: rtl/txring_poll_timer.sv
module txring_poll_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   if (CNT_W < 1) begin : g_bad_width
      $error("txring_poll_timer: CNT_W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/txring_lane_pick.sv
module txring_lane_pick #(
   parameter int unsigned LANES     = 4,
   parameter bit          BIG_ORDER = 1'b0
) (
   input  logic [8*LANES-1:0]         word,
   input  logic [$clog2(LANES)-1:0]   lane,
   output logic [7:0]                 byte_o
);

   localparam int unsigned LANE_W = $clog2(LANES);

   if (LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("txring_lane_pick: LANES must be a power of two, at least 2");
   end

   logic [7:0] lane_bytes [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      if (BIG_ORDER) begin : g_big
         assign lane_bytes[g] = word[8*(LANES-1-g) +: 8];
      end else begin : g_little
         assign lane_bytes[g] = word[8*g +: 8];
      end
   end

   assign byte_o = lane_bytes[lane[LANE_W-1:0]];

endmodule

// File: rtl/txring_dma.sv
module txring_dma
   import txring_pkg::*;
#(
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned LEN_W     = 22,
   parameter int unsigned POLL_W    = 8,
   parameter bit          BIG_ORDER = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [POLL_W-1:0] poll_interval,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ready,
   input  logic [31:0]       mem_rdata,
   output logic              st_valid,
   output logic [7:0]        st_data,
   output logic              st_first,
   output logic              st_last,
   input  logic              st_ready,
   output logic              parked
);

   localparam int unsigned LANES  = 4;
   localparam int unsigned LANE_W = $clog2(LANES);
   localparam logic [31:0] DONE_WORD = 32'(1) << DONE_BIT;

   if (ADDR_W < 5 || ADDR_W > 32) begin : g_bad_addr
      $error("txring_dma: ADDR_W must lie in 5..32");
   end
   if (LEN_W < 1 || LEN_W > 22) begin : g_bad_len
      $error("txring_dma: LEN_W must lie in 1..22");
   end
   if (POLL_W < 1) begin : g_bad_poll
      $error("txring_dma: POLL_W must be at least 1");
   end

   txr_state_e        state_q, state_d;
   logic [ADDR_W-1:0] cur_q, nxt_q, dptr_q;
   logic [LEN_W-1:0]  remain_q;
   logic              sop_q, eop_q, first_q, stop_pend_q, parked_q;
   logic [31:0]       word_q;

   logic mem_phase, beat, take, tmr_load, tmr_expired;
   logic start_cmd, stop_cmd, resume_cmd, go_idle;

   assign start_cmd  = cmd_valid && (cmd_op == CMD_START);
   assign stop_cmd   = cmd_valid && (cmd_op == CMD_STOP);
   assign resume_cmd = cmd_valid && (cmd_op == CMD_RESUME);

   assign mem_phase = (state_q == ST_CTL) || (state_q == ST_NXT) || (state_q == ST_PTR) ||
                      (state_q == ST_WORD) || (state_q == ST_DONE);
   assign beat      = mem_phase && mem_ready;
   assign take      = (state_q == ST_SEND) && st_ready;
   assign tmr_load  = (state_q == ST_CTL) && beat && mem_rdata[PARK_BIT];

   // memory side
   assign mem_req   = mem_phase;
   assign mem_we    = (state_q == ST_DONE);
   assign mem_wdata = (state_q == ST_DONE) ? DONE_WORD : '0;

   always_comb begin
      unique case (state_q)
         ST_NXT:  mem_addr = cur_q | ADDR_W'(OFS_NXT);
         ST_PTR:  mem_addr = cur_q | ADDR_W'(OFS_PTR);
         ST_WORD: mem_addr = {dptr_q[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
         ST_DONE: mem_addr = cur_q | ADDR_W'(OFS_STAT);
         default: mem_addr = cur_q | ADDR_W'(OFS_CTL);
      endcase
   end

   // stream side
   txring_lane_pick #(.LANES(LANES), .BIG_ORDER(BIG_ORDER)) i_lane_pick (
      .word   (word_q),
      .lane   (dptr_q[LANE_W-1:0]),
      .byte_o (st_data)
   );

   assign st_valid = (state_q == ST_SEND);
   assign st_first = st_valid && sop_q && first_q;
   assign st_last  = st_valid && eop_q && (remain_q == LEN_W'(1));
   assign parked   = parked_q;

   txring_poll_timer #(.CNT_W(POLL_W)) i_poll_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (poll_interval),
      .expired  (tmr_expired)
   );

   // stop: immediate outside a bus beat, otherwise once the beat completes
   assign go_idle = mem_phase ? (beat && (stop_cmd || stop_pend_q)) : stop_cmd;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (start_cmd) state_d = ST_CTL;
         ST_CTL:  if (beat) state_d = mem_rdata[PARK_BIT] ? ST_PARK : ST_NXT;
         ST_NXT:  if (beat) state_d = ST_PTR;
         ST_PTR:  if (beat) state_d = (remain_q == '0) ? ST_DONE : ST_WORD;
         ST_WORD: if (beat) state_d = ST_SEND;
         ST_SEND: if (take) begin
            if (remain_q == LEN_W'(1))        state_d = ST_DONE;
            else if (&dptr_q[LANE_W-1:0])     state_d = ST_WORD;
         end
         ST_DONE: if (beat) state_d = ST_CTL;
         ST_PARK: if (resume_cmd || tmr_expired) state_d = ST_CTL;
         default: state_d = ST_IDLE;
      endcase
      if (go_idle) state_d = ST_IDLE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         cur_q       <= '0;
         nxt_q       <= '0;
         dptr_q      <= '0;
         remain_q    <= '0;
         sop_q       <= 1'b0;
         eop_q       <= 1'b0;
         first_q     <= 1'b0;
         word_q      <= '0;
         stop_pend_q <= 1'b0;
         parked_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && start_cmd)
            cur_q <= {cmd_addr[ADDR_W-1:4], 4'b0000};
         if (state_q == ST_CTL && beat) begin
            parked_q <= mem_rdata[PARK_BIT];
            if (!mem_rdata[PARK_BIT]) begin
               sop_q    <= mem_rdata[SOP_BIT];
               eop_q    <= mem_rdata[EOP_BIT];
               remain_q <= mem_rdata[LEN_W-1:0];
            end
         end
         if (state_q == ST_NXT && beat)
            nxt_q <= {mem_rdata[ADDR_W-1:4], 4'b0000};
         if (state_q == ST_PTR && beat) begin
            dptr_q  <= mem_rdata[ADDR_W-1:0];
            first_q <= 1'b1;
         end
         if (state_q == ST_WORD && beat)
            word_q <= mem_rdata;
         if (take) begin
            dptr_q   <= dptr_q + 1'b1;
            remain_q <= remain_q - 1'b1;
            first_q  <= 1'b0;
         end
         if (state_q == ST_DONE && beat)
            cur_q <= nxt_q;
         if (state_d == ST_IDLE) begin
            stop_pend_q <= 1'b0;
            parked_q    <= 1'b0;
         end else if (stop_cmd && mem_phase) begin
            stop_pend_q <= 1'b1;
         end
      end
   end

   // ---------------- assertions ----------------
   assert_req_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   assert_byte_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid && !st_ready && !stop_cmd |=> st_valid && $stable(st_data) && $stable(st_first) && $stable(st_last));

   assert_write_is_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> (mem_addr[3:0] == OFS_STAT) && (mem_wdata == DONE_WORD));

   assert_park_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
      parked |-> !st_valid && !(mem_req && mem_we));

   assert_resume_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      parked && resume_cmd && !mem_req |=> mem_req && !mem_we);

   assert_stop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stop_cmd && !mem_req |=> !mem_req && !st_valid);

   assert_flags_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_first || st_last) |-> st_valid);

endmodule

// File: tb/test_txring_dma.sv
module test_txring_dma;

   localparam int unsigned ADDR_W = 10;
   localparam int unsigned LEN_W  = 8;
   localparam int unsigned POLL_W = 4;
   localparam time         CLK_PERIOD = 10ns;

   localparam logic [31:0] PK = 32'h8000_0000;
   localparam logic [31:0] EP = 32'h4000_0000;
   localparam logic [31:0] SP = 32'h2000_0000;
   localparam logic [31:0] XB = 32'h1800_0000;
   localparam logic [31:0] DONE = 32'h8000_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'b00;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [POLL_W-1:0] poll_interval = 4'd7;
   logic mem_req, mem_we, mem_ready, st_valid, st_first, st_last, st_ready, parked;
   logic [ADDR_W-1:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic [7:0] st_data;

   always #(CLK_PERIOD / 2) clk = ~clk;

   txring_dma #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .POLL_W(POLL_W)) i_txring_dma (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .poll_interval(poll_interval), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata), .st_valid(st_valid),
      .st_data(st_data), .st_first(st_first), .st_last(st_last), .st_ready(st_ready), .parked(parked));

   // ---------------- memory, sink and logs ----------------
   logic [31:0] mem [256];
   int   cyc = 0;
   int   mem_mode = 0, st_mode = 0;
   logic [15:0] lfsr = 16'hACE1;
   logic sw_wr = 1'b0, clr = 1'b0;
   logic [9:0] sw_addr = '0;
   logic [31:0] sw_data = '0;
   logic [9:0] watch = '0;
   logic [7:0] cap_d [256];
   logic cap_f [256];
   logic cap_l [256];
   int   cap_n = 0;
   int   rd_t [64];
   int   rd_n = 0;

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 13 + 5) & 255);
   endfunction

   function automatic logic [31:0] pat_word(input int i);
      return {pat(4*i+3), pat(4*i+2), pat(4*i+1), pat(4*i)};
   endfunction

   always @(negedge clk) begin
      logic mok, sok;
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mok = (mem_mode == 0) ? 1'b1 : (mem_mode == 1) ? cyc[0] : lfsr[0];
      sok = (st_mode == 0) ? 1'b1 : (st_mode == 1) ? !cyc[1] : lfsr[5];
      mem_ready <= mem_req && mok;
      mem_rdata <= mem[mem_addr[9:2]];
      st_ready  <= sok;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= pat_word(i);
      end else begin
         if (mem_req && mem_we && mem_ready) mem[mem_addr[9:2]] <= mem_wdata;
         if (sw_wr) mem[sw_addr[9:2]] <= sw_data;
      end
      if (clr) begin
         cap_n <= 0;
         rd_n  <= 0;
      end else begin
         if (st_valid && st_ready && cap_n < 256) begin
            cap_d[cap_n] <= st_data;
            cap_f[cap_n] <= st_first;
            cap_l[cap_n] <= st_last;
            cap_n <= cap_n + 1;
         end
         if (mem_req && !mem_we && mem_ready && mem_addr == watch && rd_n < 64) begin
            rd_t[rd_n] <= cyc;
            rd_n <= rd_n + 1;
         end
      end
      cyc <= cyc + 1;
   end

   // ---------------- checking ----------------
   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;
   logic [7:0] exp_d [256];
   logic exp_f [256];
   logic exp_l [256];
   int exp_n = 0;

   task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic sw_write(input int a, input logic [31:0] d);
      @(negedge clk);
      sw_addr = 10'(a); sw_data = d; sw_wr = 1'b1;
      @(negedge clk);
      sw_wr = 1'b0;
   endtask

   task automatic clear_logs();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      exp_n = 0;
   endtask

   task automatic put_desc(input int base, input logic [31:0] ctl, input int nxt, input int ptr);
      sw_write(base, ctl);
      sw_write(base + 4, 32'(nxt));
      sw_write(base + 8, 32'(ptr));
      sw_write(base + 12, 32'h0);
   endtask

   task automatic add_exp(input int ptr, input int len, input bit sop, input bit eop);
      for (int k = 0; k < len; k++) begin
         exp_d[exp_n] = pat(ptr + k);
         exp_f[exp_n] = sop && (k == 0);
         exp_l[exp_n] = eop && (k == len - 1);
         exp_n++;
      end
   endtask

   task automatic issue(input logic [1:0] op, input int a);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = ADDR_W'(a);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'b00;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wait_parked(input int limit);
      for (int i = 0; i < limit && !parked; i++) @(negedge clk);
   endtask

   task automatic check_stream(input string req, input string tag);
      int bad_d = 0, bad_f = 0, first_bad = -1;
      chk(cap_n == exp_n, req, {tag, " byte count"}, cap_n, exp_n);
      for (int i = 0; i < exp_n && i < cap_n; i++) begin
         if (cap_d[i] !== exp_d[i]) begin bad_d++; if (first_bad < 0) first_bad = i; end
         if (cap_f[i] !== exp_f[i] || cap_l[i] !== exp_l[i]) bad_f++;
      end
      chk(bad_d == 0, "R4", {tag, " byte values (mismatches)"}, bad_d, 0);
      chk(bad_f == 0, "R5", {tag, " first/last flags (mismatches)"}, bad_f, 0);
   endtask

   initial begin
      watch = 10'h3FF;
      do_reset();
      @(negedge clk);
      // R1: reset state
      chk(!mem_req && !st_valid && !parked, "R1", "idle after reset",
          {mem_req, st_valid, parked}, 0);
      repeat (5) @(negedge clk);
      chk(!mem_req, "R1", "no access without start", mem_req, 0);

      // ring sweep over memory stall and stream backpressure patterns (R3..R7, R10)
      for (int mm = 0; mm < 3; mm++) begin
         for (int sm = 0; sm < 3; sm++) begin
            string tag;
            tag = $sformatf("ring mm%0d sm%0d", mm, sm);
            mem_mode = mm; st_mode = sm;
            do_reset();
            put_desc(12'h000, SP | EP | XB | 32'd5, 12'h010, 12'h101);
            put_desc(12'h010, SP | 32'd6, 12'h020, 12'h143);
            put_desc(12'h020, EP | XB | 32'd3, 12'h030, 12'h180);
            put_desc(12'h030, SP | EP | 32'd0, 12'h040, 12'h1C0);
            put_desc(12'h040, PK | SP | EP | 32'd2, 12'h000, 12'h1E2);
            clear_logs();
            add_exp(12'h101, 5, 1'b1, 1'b1);
            add_exp(12'h143, 6, 1'b1, 1'b0);
            add_exp(12'h180, 3, 1'b0, 1'b1);
            issue(2'b01, 0);
            wait_parked(4000);
            repeat (4) @(negedge clk);
            // R3: byte counts from the low bits, bits 28/27 ignored
            check_stream("R3", tag);
            chk(mem[1 * 4 - 1] == DONE && mem[7] == DONE, "R6", {tag, " done flags d0 d1"},
                {mem[3], mem[7]}, {DONE, DONE});
            chk(mem[11] == DONE && mem[15] == DONE, "R6", {tag, " done flags d2 d3(zero length)"},
                {mem[11], mem[15]}, {DONE, DONE});
            chk(mem[19] == 32'h0 && parked, "R7", {tag, " parked desc untouched"},
                {mem[19], 31'h0, parked}, {32'h0, 32'h1});
         end
      end

      // R7: poll interval sweep, zero-wait memory
      mem_mode = 0; st_mode = 0;
      watch = 10'h040;
      for (int p = 0; p < 16; p++) begin
         int bad;
         poll_interval = 4'(p);
         repeat (20) @(negedge clk);
         clear_logs();
         repeat (3 * (p + 2) + 4) @(negedge clk);
         bad = 0;
         for (int i = 1; i < rd_n; i++) if (rd_t[i] - rd_t[i-1] != p + 2) bad++;
         chk(rd_n >= 2 && bad == 0, "R7", $sformatf("re-read gap P=%0d (bad gaps, reads)", p),
             {bad, rd_n}, p + 2);
      end

      // R8: clear park bit in memory, poll picks it up; R6: wrap to first descriptor
      poll_interval = 4'd3;
      sw_write(12'h000, PK | SP | EP | 32'd1);
      sw_write(12'h00C, 32'h0);
      watch = 10'h000;
      clear_logs();
      add_exp(12'h1E2, 2, 1'b1, 1'b1);
      sw_write(12'h040, SP | EP | 32'd2);
      repeat (60) @(negedge clk);
      check_stream("R8", "poll release");
      chk(mem[19] == DONE, "R8", "released desc done", mem[19], DONE);
      chk(rd_n > 0 && parked && mem[3] == 32'h0, "R6", "wrap to first and park there",
          {rd_n, 31'h0, parked}, 1);

      // R8: resume command fetches on the following cycle
      poll_interval = 4'd15;
      repeat (8) @(negedge clk);
      begin
         int seen;
         seen = rd_n;
         for (int i = 0; i < 40 && rd_n == seen; i++) @(negedge clk);
      end
      sw_write(12'h010, PK | 32'd1);
      sw_write(12'h000, SP | EP | 32'd1);
      clear_logs();
      add_exp(12'h101, 1, 1'b1, 1'b1);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'b11;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_op = 2'b00;
      chk(mem_req && !mem_we && mem_addr == 10'h000, "R8", "resume fetch next cycle",
          {mem_req, mem_we, 22'h0, mem_addr}, {1'b1, 1'b0, 32'h0});
      repeat (40) @(negedge clk);
      check_stream("R8", "resume");
      chk(mem[3] == DONE, "R8", "resumed desc done", mem[3], DONE);

      // R9: stop in the middle of a payload
      do_reset();
      put_desc(12'h000, SP | EP | 32'd40, 12'h010, 12'h200);
      clear_logs();
      issue(2'b01, 0);
      for (int i = 0; i < 500 && cap_n < 10; i++) @(negedge clk);
      issue(2'b10, 0);
      repeat (10) @(negedge clk);
      chk(!mem_req && !st_valid && !parked, "R9", "idle after stop",
          {mem_req, st_valid, parked}, 0);
      chk(cap_n < 40, "R9", "payload cut short", cap_n, 39);
      chk(mem[3] == 32'h0, "R9", "no done flag on stopped desc", mem[3], 0);

      // R2: restart at unaligned address
      put_desc(12'h010, SP | EP | 32'd2, 12'h020, 12'h300);
      put_desc(12'h020, PK, 12'h000, 12'h000);
      watch = 10'h010;
      clear_logs();
      add_exp(12'h300, 2, 1'b1, 1'b1);
      issue(2'b01, 12'h013);
      wait_parked(400);
      repeat (4) @(negedge clk);
      chk(rd_n == 1, "R2", "start fetch at aligned address", rd_n, 1);
      check_stream("R2", "restart");
      chk(mem[7] == DONE, "R2", "restart desc done", mem[7], DONE);

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule